// File: doc/BRIEF.md
# Shared-Sense-Amp Bank State Tracker

This block follows the open or closed state of every bank in a packetized DRAM device whose banks pair up around shared row buffers. A memory controller passes it each decoded command it is about to issue. The block updates a per-bank open flag and the row held by each open bank. It rejects commands that the device would refuse or that would corrupt a buffer, and in that case it raises a one-cycle error strobe with a code.

There is one more row buffer than there are banks. Buffer k lies between bank k-1 and bank k, so a bank cannot open while either of its neighbours holds a row. A bank can be closed by any of three commands:
- a row precharge;
- the auto-precharge variant of a column read, write or column no-op;
- an extended precharge. This one is legal only straight after a read, or after a write whose mask flag is clear.

The number of banks open at one time is also capped. The state is updated on the clock edge that samples the command. The error strobe is registered on that same edge.

Top module: `bst_tracker`

## Requirements
- R1: While `rst` is high, every bank is closed on the next clock edge and `errValid` is low.
- R2: A valid activate (`cmdOp`=1) to bank b opens b on the clock edge that samples it, and the row on `openRows[b*ROW_W +: ROW_W]` becomes `cmdRow`. This holds when b, b-1 and b+1 are all closed and fewer than MAX_OPEN banks are open. The row stays there until b closes.
- R3: An activate to a bank that is itself open, or whose lower or upper neighbour is open, raises `errValid` with `errCode`=1 (buffer conflict) and changes no bank state.
- R4: An activate that would make more than MAX_OPEN banks (default 4) open at once raises `errCode`=1 and changes no bank state.
- R5: A row precharge (`cmdOp`=2) closes the addressed bank. A precharge to a bank that is already closed changes nothing and raises no error.
- R6: A column read (`cmdOp`=3) or write (`cmdOp`=4) to a closed bank raises `errCode`=2 and changes no bank state.
- R7: A read, write or column no-op (`cmdOp`=5) with `cmdAutoPre`=1 closes an open addressed bank. Without auto-precharge the bank stays open. A column no-op never raises an error.
- R8: An extended precharge (`cmdOp`=6) closes the addressed bank only if the most recent valid command was an accepted read, or an accepted write with `cmdMask`=0. Idle cycles do not break this chain. Otherwise it raises `errCode`=3 and changes no bank state.
- R9: `errValid` is high for exactly the one cycle after an offending command, and its code is nonzero. A cycle with `cmdValid` low changes no state and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Command: 0 idle, 1 activate, 2 precharge, 3 read, 4 write, 5 column no-op, 6 extended precharge |
| cmdBank | input | BANK_W (4) | Addressed bank |
| cmdRow | input | ROW_W (9) | Row for activate |
| cmdMask | input | 1 | Write carries a byte mask |
| cmdAutoPre | input | 1 | Column command closes the bank afterwards |
| bankOpen | output | NUM_BANKS (16) | Per-bank open flag |
| openRows | output | NUM_BANKS*ROW_W (144) | Row held by each bank, bank b at bits b*ROW_W upward |
| errValid | output | 1 | Rejected-command strobe |
| errCode | output | 2 | 0 none, 1 conflict, 2 closed-bank access, 3 misplaced extended precharge |

## Verification
The occupancy limit is the hardest case to reach. The neighbour rule already blocks most activates, so four banks have to be opened in a spaced pattern, for example 0, 2, 13 and 15. Only then does a fifth activate to a bank with no open neighbour test the limit rather than the adjacency rule. The stimulus table builds that pattern, frees one slot by precharging bank 13, and then shows the same activate succeeding. It also separates a legal extended-precharge chain from a broken one:
- a chain broken by a masked write;
- a chain broken by a rejected read;
- a chain broken by a previous extended precharge;
- a legal chain that spans an idle cycle.

// File: rtl/bst_pkg.sv
package bst_pkg;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_ACT  = 3'd1,
    OP_PRE  = 3'd2,
    OP_RD   = 3'd3,
    OP_WR   = 3'd4,
    OP_CNOP = 3'd5,
    OP_XPRE = 3'd6
  } cmdOp_e;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_CONFLICT = 2'd1,
    ERR_CLOSED   = 2'd2,
    ERR_XPRE     = 2'd3
  } errCode_e;

  // strobes from control to the bank-state datapath
  typedef struct packed {
    logic     openBank;
    logic     closeBank;
    logic     errStb;
    errCode_e errCode;
  } ctrlStb_t;

endpackage

// File: rtl/bst_bank_state.sv
module bst_bank_state
  import bst_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  parameter int ROW_W     = 9,
  parameter int MAX_OPEN  = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = $clog2(NUM_BANKS + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  ctrlStb_t                   stb,
  input  logic [BANK_W-1:0]          cmdBank,
  input  logic [ROW_W-1:0]           cmdRow,
  output logic [NUM_BANKS-1:0]       bankOpen,
  output logic [NUM_BANKS*ROW_W-1:0] openRows,
  output logic [NUM_BANKS-1:0]       blocked,
  output logic                       atLimit
);

  logic [NUM_BANKS-1:0] lowerOpen;
  logic [NUM_BANKS-1:0] upperOpen;
  logic [CNT_W-1:0]     openCount;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
      logic             isOpen;
      logic [ROW_W-1:0] rowReg;
      logic             hit;

      assign hit = (cmdBank == BANK_W'(gi));

      always_ff @(posedge clk) begin
        if (rst) begin
          isOpen <= 1'b0;
          rowReg <= '0;
        end else if (stb.openBank && hit) begin
          isOpen <= 1'b1;
          rowReg <= cmdRow;
        end else if (stb.closeBank && hit) begin
          isOpen <= 1'b0;
        end
      end

      assign bankOpen[gi]                   = isOpen;
      assign openRows[gi*ROW_W +: ROW_W]    = rowReg;
    end
  endgenerate

  // buffer k is shared by banks k-1 and k: a bank is blocked when it or a neighbour is open
  assign lowerOpen = {bankOpen[NUM_BANKS-2:0], 1'b0};
  assign upperOpen = {1'b0, bankOpen[NUM_BANKS-1:1]};
  assign blocked   = bankOpen | lowerOpen | upperOpen;

  always_comb begin
    openCount = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      openCount = openCount + CNT_W'(bankOpen[i]);
    end
  end

  assign atLimit = (openCount >= CNT_W'(MAX_OPEN));

endmodule

// File: rtl/bst_ctrl.sv
module bst_ctrl
  import bst_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmdValid,
  input  logic [2:0]           cmdOp,
  input  logic [BANK_W-1:0]    cmdBank,
  input  logic                 cmdMask,
  input  logic                 cmdAutoPre,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic [NUM_BANKS-1:0] blocked,
  input  logic                 atLimit,
  output ctrlStb_t             stb,
  output logic                 errValid,
  output logic [1:0]           errCode
);

  cmdOp_e op;
  logic   selOpen;
  logic   xpOk;
  logic   xpNext;

  assign op      = cmdOp_e'(cmdOp);
  assign selOpen = bankOpen[cmdBank];

  always_comb begin
    stb = '{openBank: 1'b0, closeBank: 1'b0, errStb: 1'b0, errCode: ERR_NONE};
    if (cmdValid) begin
      case (op)
        OP_ACT: begin
          if (blocked[cmdBank] || atLimit) begin
            stb.errStb  = 1'b1;
            stb.errCode = ERR_CONFLICT;
          end else begin
            stb.openBank = 1'b1;
          end
        end
        OP_PRE:  stb.closeBank = 1'b1;
        OP_RD, OP_WR: begin
          if (!selOpen) begin
            stb.errStb  = 1'b1;
            stb.errCode = ERR_CLOSED;
          end else begin
            stb.closeBank = cmdAutoPre;
          end
        end
        OP_CNOP: stb.closeBank = cmdAutoPre;
        OP_XPRE: begin
          if (!xpOk) begin
            stb.errStb  = 1'b1;
            stb.errCode = ERR_XPRE;
          end else begin
            stb.closeBank = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // extended precharge is allowed only after an accepted read or unmasked write
  always_comb begin
    xpNext = xpOk;
    if (cmdValid) begin
      xpNext = selOpen && ((op == OP_RD) || ((op == OP_WR) && !cmdMask));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xpOk     <= 1'b0;
      errValid <= 1'b0;
      errCode  <= 2'd0;
    end else begin
      xpOk     <= xpNext;
      errValid <= stb.errStb;
      errCode  <= stb.errCode;
    end
  end

endmodule

// File: rtl/bst_tracker.sv
module bst_tracker
  import bst_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  parameter int ROW_W     = 9,
  parameter int MAX_OPEN  = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmdValid,
  input  logic [2:0]                 cmdOp,
  input  logic [BANK_W-1:0]          cmdBank,
  input  logic [ROW_W-1:0]           cmdRow,
  input  logic                       cmdMask,
  input  logic                       cmdAutoPre,
  output logic [NUM_BANKS-1:0]       bankOpen,
  output logic [NUM_BANKS*ROW_W-1:0] openRows,
  output logic                       errValid,
  output logic [1:0]                 errCode
);

  ctrlStb_t             stb;
  logic [NUM_BANKS-1:0] blocked;
  logic                 atLimit;

  bst_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdBank(cmdBank),
    .cmdMask(cmdMask), .cmdAutoPre(cmdAutoPre), .bankOpen(bankOpen),
    .blocked(blocked), .atLimit(atLimit), .stb(stb),
    .errValid(errValid), .errCode(errCode)
  );

  bst_bank_state #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .MAX_OPEN(MAX_OPEN)) u_state (
    .clk(clk), .rst(rst), .stb(stb), .cmdBank(cmdBank), .cmdRow(cmdRow),
    .bankOpen(bankOpen), .openRows(openRows), .blocked(blocked), .atLimit(atLimit)
  );

endmodule

// File: rtl/bst_checker.sv
module bst_checker #(
  parameter int NUM_BANKS = 16,
  parameter int MAX_OPEN  = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cmdValid,
  input logic [2:0]           cmdOp,
  input logic [BANK_W-1:0]    cmdBank,
  input logic [NUM_BANKS-1:0] bankOpen,
  input logic                 errValid,
  input logic [1:0]           errCode
);

  logic adjacentPair;
  assign adjacentPair = |(bankOpen[NUM_BANKS-2:0] & bankOpen[NUM_BANKS-1:1]);

  assert_reset_closes_R1: assert property (@(posedge clk)
    rst |=> (bankOpen == '0) && !errValid);

  assert_no_adjacent_R3: assert property (@(posedge clk) disable iff (rst)
    !adjacentPair);

  assert_open_limit_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(bankOpen) <= MAX_OPEN);

  assert_closed_access_R6: assert property (@(posedge clk) disable iff (rst)
    cmdValid && (cmdOp == 3'd3 || cmdOp == 3'd4) && !bankOpen[cmdBank]
    |=> errValid && errCode == 2'd2);

  assert_xpre_source_R8: assert property (@(posedge clk) disable iff (rst)
    errValid && errCode == 2'd3 |-> $past(cmdOp) == 3'd6 && $past(cmdValid));

  assert_code_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
    errValid |-> errCode != 2'd0);

  assert_reject_stable_R9: assert property (@(posedge clk) disable iff (rst)
    errValid |-> bankOpen == $past(bankOpen));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !cmdValid |=> !errValid && bankOpen == $past(bankOpen));

endmodule

bind bst_tracker bst_checker #(.NUM_BANKS(NUM_BANKS), .MAX_OPEN(MAX_OPEN)) u_chk (
  .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdBank(cmdBank),
  .bankOpen(bankOpen), .errValid(errValid), .errCode(errCode)
);

// File: tb/tb_bst_tracker.sv
module tb_bst_tracker;

  localparam int NB = 16;
  localparam int RW = 9;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           cmdValid = 1'b0;
  logic [2:0]     cmdOp = 3'd0;
  logic [3:0]     cmdBank = 4'd0;
  logic [RW-1:0]  cmdRow = '0;
  logic           cmdMask = 1'b0;
  logic           cmdAutoPre = 1'b0;
  logic [NB-1:0]  bankOpen;
  logic [NB*RW-1:0] openRows;
  logic           errValid;
  logic [1:0]     errCode;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  bst_tracker dut (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdBank(cmdBank),
    .cmdRow(cmdRow), .cmdMask(cmdMask), .cmdAutoPre(cmdAutoPre),
    .bankOpen(bankOpen), .openRows(openRows), .errValid(errValid), .errCode(errCode)
  );

  typedef struct packed {
    logic        vld;
    logic [2:0]  op;
    logic [3:0]  bank;
    logic [8:0]  row;
    logic        mask;
    logic        ap;
    logic [1:0]  err;
    logic [15:0] open;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 3'd1, 4'd0,  9'd5,   1'b0, 1'b0, 2'd0, 16'h0001}, // R2 act b0
    '{1'b1, 3'd1, 4'd1,  9'd7,   1'b0, 1'b0, 2'd1, 16'h0001}, // R3 lower neighbour
    '{1'b1, 3'd1, 4'd2,  9'h1FF, 1'b0, 1'b0, 2'd0, 16'h0005}, // R2 act b2
    '{1'b1, 3'd1, 4'd0,  9'd3,   1'b0, 1'b0, 2'd1, 16'h0005}, // R3 self open
    '{1'b1, 3'd3, 4'd4,  9'd0,   1'b0, 1'b0, 2'd2, 16'h0005}, // R6 read closed
    '{1'b1, 3'd3, 4'd2,  9'd0,   1'b0, 1'b0, 2'd0, 16'h0005}, // R7 read keeps open
    '{1'b1, 3'd6, 4'd2,  9'd0,   1'b0, 1'b0, 2'd0, 16'h0001}, // R8 xpre after read
    '{1'b1, 3'd6, 4'd0,  9'd0,   1'b0, 1'b0, 2'd3, 16'h0001}, // R8 xpre after xpre
    '{1'b1, 3'd4, 4'd0,  9'd0,   1'b1, 1'b0, 2'd0, 16'h0001}, // masked write
    '{1'b1, 3'd6, 4'd0,  9'd0,   1'b0, 1'b0, 2'd3, 16'h0001}, // R8 after masked write
    '{1'b1, 3'd4, 4'd0,  9'd0,   1'b0, 1'b0, 2'd0, 16'h0001}, // unmasked write
    '{1'b0, 3'd1, 4'd9,  9'd0,   1'b0, 1'b0, 2'd0, 16'h0001}, // R9 invalid ignored
    '{1'b1, 3'd6, 4'd0,  9'd0,   1'b0, 1'b0, 2'd0, 16'h0000}, // R8 across idle
    '{1'b1, 3'd1, 4'd15, 9'd3,   1'b0, 1'b0, 2'd0, 16'h8000}, // R2 top bank
    '{1'b1, 3'd1, 4'd14, 9'd3,   1'b0, 1'b0, 2'd1, 16'h8000}, // R3 upper neighbour
    '{1'b1, 3'd1, 4'd13, 9'd9,   1'b0, 1'b0, 2'd0, 16'hA000},
    '{1'b1, 3'd1, 4'd0,  9'd1,   1'b0, 1'b0, 2'd0, 16'hA001},
    '{1'b1, 3'd1, 4'd2,  9'd2,   1'b0, 1'b0, 2'd0, 16'hA005},
    '{1'b1, 3'd1, 4'd5,  9'd4,   1'b0, 1'b0, 2'd1, 16'hA005}, // R4 fifth bank
    '{1'b1, 3'd2, 4'd6,  9'd0,   1'b0, 1'b0, 2'd0, 16'hA005}, // R5 pre closed
    '{1'b1, 3'd2, 4'd13, 9'd0,   1'b0, 1'b0, 2'd0, 16'h8005}, // R5 pre open
    '{1'b1, 3'd1, 4'd5,  9'd4,   1'b0, 1'b0, 2'd0, 16'h8025}, // R4 slot freed
    '{1'b1, 3'd3, 4'd5,  9'd0,   1'b0, 1'b1, 2'd0, 16'h8005}, // R7 read auto-pre
    '{1'b1, 3'd4, 4'd0,  9'd0,   1'b0, 1'b1, 2'd0, 16'h8004}, // R7 write auto-pre
    '{1'b1, 3'd5, 4'd2,  9'd0,   1'b0, 1'b0, 2'd0, 16'h8004}, // R7 cnop no ap
    '{1'b1, 3'd5, 4'd2,  9'd0,   1'b0, 1'b1, 2'd0, 16'h8000}, // R7 cnop ap
    '{1'b1, 3'd5, 4'd3,  9'd0,   1'b0, 1'b1, 2'd0, 16'h8000}, // R7 cnop closed
    '{1'b1, 3'd3, 4'd0,  9'd0,   1'b0, 1'b0, 2'd2, 16'h8000}, // R6 read closed
    '{1'b1, 3'd6, 4'd15, 9'd0,   1'b0, 1'b0, 2'd3, 16'h8000}, // R8 after rejected read
    '{1'b1, 3'd4, 4'd1,  9'd0,   1'b0, 1'b0, 2'd2, 16'h8000}, // R6 write closed
    '{1'b1, 3'd2, 4'd15, 9'd0,   1'b0, 1'b0, 2'd0, 16'h0000}  // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] op, input logic [3:0] b,
                       input logic [8:0] r, input logic m, input logic ap);
    cmdValid = v; cmdOp = op; cmdBank = b; cmdRow = r; cmdMask = m; cmdAutoPre = ap;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1 reset open flags", 32'(bankOpen), 32'h0);
    check("R1 reset err strobe", 32'(errValid), 32'h0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].vld, TBL[i].op, TBL[i].bank, TBL[i].row, TBL[i].mask, TBL[i].ap);
      check($sformatf("R9 errValid vec %0d", i), 32'(errValid), 32'(TBL[i].err != 2'd0));
      if (TBL[i].err != 2'd0)
        check($sformatf("R3/R4/R6/R8 errCode vec %0d", i), 32'(errCode), 32'(TBL[i].err));
      check($sformatf("R2/R5/R7 bankOpen vec %0d", i), 32'(bankOpen), 32'(TBL[i].open));
      if (TBL[i].vld && TBL[i].op == 3'd1 && TBL[i].err == 2'd0)
        check($sformatf("R2 row vec %0d", i), 32'(openRows[TBL[i].bank*RW +: RW]),
              32'(TBL[i].row));
    end

    // R2: row held across unrelated traffic
    drive(1'b1, 3'd1, 4'd7, 9'h0AB, 1'b0, 1'b0);
    drive(1'b1, 3'd1, 4'd3, 9'h011, 1'b0, 1'b0);
    drive(1'b1, 3'd3, 4'd3, 9'h000, 1'b0, 1'b0);
    drive(1'b1, 3'd2, 4'd3, 9'h000, 1'b0, 1'b0);
    check("R2 row retained", 32'(openRows[7*RW +: RW]), 32'h0AB);
    check("R2 open after traffic", 32'(bankOpen), 32'h0080);

    // R9: strobe lasts one cycle
    drive(1'b1, 3'd1, 4'd8, 9'h000, 1'b0, 1'b0);
    check("R9 conflict strobe", 32'(errValid), 32'h1);
    @(negedge clk);
    check("R9 strobe drops", 32'(errValid), 32'h0);

    // R1: reset mid-operation
    drive(1'b1, 3'd1, 4'd11, 9'h033, 1'b0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset closes", 32'(bankOpen), 32'h0);
    check("R1 mid reset err", 32'(errValid), 32'h0);
    rst = 1'b0;
    drive(1'b1, 3'd6, 4'd0, 9'h000, 1'b0, 1'b0);
    check("R8 xpre after reset", 32'(errCode), 32'h3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule